// File: doc/BRIEF.md
# Up/Down Timer Channel with Handshake-Cleared Status Flags

This block is one 16-bit timer channel. It has a counter that steps up or down, two general registers (A and B) and an 8-bit status word. Each general register works in one of two modes. In compare mode, its flag sets when the running count equals it. In capture mode, a synchronised edge on its capture pin copies the count into it and sets its flag. The counter also raises an overflow flag when it wraps upward and an underflow flag when it wraps downward. The status word also shows the current counting direction.

Software clears a flag in two steps. It first reads the flag while it is 1, which arms that flag. It then writes 0 to that bit, which clears it. A request-serviced pulse from an external transfer engine can also clear flag A or flag B, unless the request asks to keep the flag. Each flag drives its own interrupt request, gated by an enable.

Each flag is held by a three-state machine with these states:
- `FLG_IDLE`: the flag is clear.
- `FLG_PEND`: the flag is set but not armed.
- `FLG_ARMED`: the flag is set and has been read as 1.

The machine moves between states as follows:
- IDLE→PEND on a set event.
- PEND→ARMED on a status read.
- ARMED→IDLE on a write of 0 to the bit.
- PEND/ARMED→IDLE on an unkept service pulse (flags A and B only).
- ARMED→PEND on a new set event, which drops the arming.
- PEND→PEND on a set event or a write without arming.

Top module: `updown_timer_flags`

## Requirements
- R1: The status word reads from address 0. Its layout and reset value are:
  - bit 7 reads 1;
  - bits 3:2 and 15:8 read 0;
  - after reset, with counting up selected, it reads 0x00C0;
  - after reset, the counter and both general registers read 0.
- R2: Status bit 6 reads 1 while `cnt_up` is 1 and 0 while it is 0. Writes cannot change it.
- R3: When an enabled up-count steps the counter from 0xFFFF to 0x0000, the overflow flag (status bit 4) sets at that clock edge.
- R4: When an enabled down-count steps the counter from 0x0000 to 0xFFFF, the underflow flag (status bit 5) sets at that clock edge.
- R5: A flag clears when software reads it as 1 in a status read and then writes 0 to its bit. Writing 1 to the bit leaves the flag set.
- R6: Writing 0 to a set flag that has not been read as 1 since it set leaves the flag set.
- R7: Register A (flag bit 0) or B (flag bit 1) is in compare mode when its `cap_mode` bit is 0. In that mode, its flag sets at any edge where counting is enabled and the counter equals the register.
- R8: A general register is in capture mode when its `cap_mode` bit is 1. With `cap_fall`=0, a rising edge on its `cap_in` pin does two things: it copies the counter into the register and it sets the register's flag. Both happen on the third clock edge after the pin changes.
- R9: With `cap_fall`=1, only a falling edge captures. A rising edge leaves both the register and its flag unchanged.
- R10: A one-cycle `svc_req` pulse clears flag A (bit 0) or B (bit 1) when the matching `svc_keep` bit is 0. It has no effect when `svc_keep` is 1.
- R11: A set event in the same cycle as a clearing write leaves the flag set. It also drops the arming, so a later write of 0 needs a fresh read before it clears the flag.
- R12: The `irq` output maps as follows: bit 0 is A, bit 1 is B, bit 2 is overflow and bit 3 is underflow. Each bit is 1 exactly when its flag is set and its `irq_en` bit is 1.
- R13: The counter changes by ±1 on each edge where `cnt_en` is 1. A bus write to address 1 loads it instead. Addresses 2 and 3 hold registers A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter step enable |
| cnt_up | input | 1 | 1 counts up, 0 counts down |
| cap_mode | input | 2 | Per register: 1 capture, 0 compare (bit 0 = A) |
| cap_fall | input | 2 | Per register capture edge: 1 falling, 0 rising |
| cap_in | input | 2 | Asynchronous capture pins |
| svc_req | input | 2 | Request-serviced pulse for flags A/B |
| svc_keep | input | 2 | Keep the flag when serviced |
| irq_en | input | 4 | Interrupt enables (A, B, overflow, underflow) |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq | output | 4 | Gated interrupt requests |

## Verification
The bound checker watches several behaviours on every cycle:
- overflow and underflow flags set at the wrap edge;
- overflow never drops without a preceding write of 0;
- a write of 1 never clears a flag;
- the reserved status bits hold their constant values;
- an interrupt never fires while its enable is low.

Some behaviours only the bench's scenarios can show. These are the read-before-write arming history, the capture latency and captured value, edge selection, the service pulse with and without keep, and the set-wins collision with its loss of arming. Each of them needs a planned sequence of bus operations and pin events.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 2;
    localparam int N_FLAGS  = 4;
    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_GRA  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_GRB  = 2'd3;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_PEND  = 2'd1,
        FLG_ARMED = 2'd2
    } flag_state_e;

    // flag index i -> status bit: A=0, B=1, overflow=4, underflow=5
    function automatic int stat_bit(input int i);
        return (i < 2) ? i : i + 2;
    endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         up,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         udf_evt
);
    localparam logic [W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (en)     cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
    end

    assign ovf_evt = en && !load && up  && (cnt == ALL_ONES);
    assign udf_evt = en && !load && !up && (cnt == '0);
endmodule

// File: rtl/tmr_gr_channel.sv
module tmr_gr_channel #(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         fall_edge,
    input  logic         cap_in,
    input  logic         cnt_en,
    input  logic [W-1:0] cnt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] gr,
    output logic         evt
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            s_now;
    logic            edge_hit;
    logic            cap_evt;
    logic            cmp_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], cap_in};
            prev_q <= sync_q[SYNC-1];
        end
    end

    assign s_now    = sync_q[SYNC-1];
    assign edge_hit = fall_edge ? (prev_q && !s_now) : (s_now && !prev_q);
    assign cap_evt  = cap_mode && edge_hit;
    assign cmp_evt  = !cap_mode && cnt_en && (cnt == gr);
    assign evt      = cap_evt || cmp_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gr <= '0;
        else if (cap_evt) gr <= cnt;
        else if (wr)      gr <= wdata;
    end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell
    import tmr_pkg::*;
#(
    parameter bit HAS_SVC = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wr_bit,
    input  logic svc,
    input  logic keep,
    output logic flag
);
    flag_state_e state_q, state_d;
    logic svc_clr;

    assign svc_clr = HAS_SVC && svc && !keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (set_evt) state_d = FLG_PEND;
            end
            FLG_PEND: begin
                if (set_evt)      state_d = FLG_PEND;
                else if (svc_clr) state_d = FLG_IDLE;
                else if (rd_stat) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (set_evt)                  state_d = FLG_PEND;
                else if (svc_clr)             state_d = FLG_IDLE;
                else if (wr_stat && !wr_bit)  state_d = FLG_IDLE;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q != FLG_IDLE);
    end
endmodule

// File: rtl/updown_timer_flags.sv
module updown_timer_flags
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_en,
    input  logic        cnt_up,
    input  logic [1:0]  cap_mode,
    input  logic [1:0]  cap_fall,
    input  logic [1:0]  cap_in,
    input  logic [1:0]  svc_req,
    input  logic [1:0]  svc_keep,
    input  logic [3:0]  irq_en,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [3:0]  irq
);
    logic [CNT_W-1:0]   cnt_q;
    logic               ovf_evt, udf_evt;
    logic [CNT_W-1:0]   gr_q  [2];
    logic [1:0]         gr_evt;
    logic [N_FLAGS-1:0] set_evt;
    logic [N_FLAGS-1:0] flg;
    logic               rd_stat, wr_stat;

    assign rd_stat = bus_rd && (bus_addr == ADR_STAT);
    assign wr_stat = bus_wr && (bus_addr == ADR_STAT);

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .up(cnt_up),
        .load(bus_wr && (bus_addr == ADR_CNT)), .load_val(bus_wdata),
        .cnt(cnt_q), .ovf_evt(ovf_evt), .udf_evt(udf_evt)
    );

    for (genvar g = 0; g < 2; g++) begin : g_gr
        localparam logic [ADDR_W-1:0] MY_ADR = (g == 0) ? ADR_GRA : ADR_GRB;
        tmr_gr_channel #(.W(CNT_W), .SYNC(2)) u_gr (
            .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode[g]),
            .fall_edge(cap_fall[g]), .cap_in(cap_in[g]), .cnt_en(cnt_en),
            .cnt(cnt_q), .wr(bus_wr && (bus_addr == MY_ADR)),
            .wdata(bus_wdata), .gr(gr_q[g]), .evt(gr_evt[g])
        );
    end

    assign set_evt = {udf_evt, ovf_evt, gr_evt};

    for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
        localparam int  SB  = stat_bit(f);
        localparam bit  SVC = (f < 2);
        tmr_flag_cell #(.HAS_SVC(SVC)) u_flag (
            .clk(clk), .rst_n(rst_n), .set_evt(set_evt[f]),
            .rd_stat(rd_stat), .wr_stat(wr_stat), .wr_bit(bus_wdata[SB]),
            .svc(SVC ? svc_req[f % 2] : 1'b0),
            .keep(SVC ? svc_keep[f % 2] : 1'b0),
            .flag(flg[f])
        );
    end

    always_comb begin
        unique case (bus_addr)
            ADR_STAT: bus_rdata = {8'h00, 1'b1, cnt_up, flg[3], flg[2], 2'b00, flg[1], flg[0]};
            ADR_CNT:  bus_rdata = cnt_q;
            ADR_GRA:  bus_rdata = gr_q[0];
            default:  bus_rdata = gr_q[1];
        endcase
    end

    assign irq = flg & irq_en;
endmodule

// File: rtl/tmr_flags_checker.sv
module tmr_flags_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cnt_en,
    input logic        cnt_up,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic [1:0]  svc_req,
    input logic [3:0]  irq_en,
    input logic [3:0]  irq,
    input logic [15:0] cnt_q,
    input logic [3:0]  flg
);
    logic cnt_load;
    assign cnt_load = bus_wr && (bus_addr == 2'd1);

    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_up && !cnt_load && cnt_q == 16'hFFFF) |=> (flg[2] && cnt_q == 16'h0000));

    assert_udf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_up && !cnt_load && cnt_q == 16'h0000) |=> (flg[3] && cnt_q == 16'hFFFF));

    assert_write1_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flg[0] && bus_wr && bus_addr == 2'd0 && bus_wdata[0] && !svc_req[0]) |=> flg[0]);

    assert_ovf_clear_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flg[2]) |-> $past(bus_wr && bus_addr == 2'd0 && !bus_wdata[4]));

    assert_reserved_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[7] && bus_rdata[3:2] == 2'b00 && bus_rdata[15:8] == 8'h00));

    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~irq_en) == 4'b0000);
endmodule

bind updown_timer_flags tmr_flags_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .svc_req(svc_req), .irq_en(irq_en),
    .irq(irq), .cnt_q(cnt_q), .flg(flg)
);

// File: tb/updown_timer_flags_bench.sv
module updown_timer_flags_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, cnt_up = 1'b1;
    logic [1:0]  cap_mode = 2'b11, cap_fall = 2'b00, cap_in = 2'b00;
    logic [1:0]  svc_req = 2'b00, svc_keep = 2'b00;
    logic [3:0]  irq_en = 4'hF;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0, failures = 0;
    logic done = 1'b0;
    logic [15:0] rv;

    always #5 clk = ~clk;

    updown_timer_flags u_updown_timer_flags (.*);

    // {start, up, steps, end count, overflow, underflow}
    localparam logic [38:0] VEC [6] = '{
        {16'hFFFE, 1'b1, 4'd3, 16'h0001, 1'b1, 1'b0},
        {16'h0001, 1'b0, 4'd3, 16'hFFFE, 1'b0, 1'b1},
        {16'h1234, 1'b1, 4'd5, 16'h1239, 1'b0, 1'b0},
        {16'h0005, 1'b0, 4'd4, 16'h0001, 1'b0, 1'b0},
        {16'hFFFF, 1'b0, 4'd2, 16'hFFFD, 1'b0, 1'b0},
        {16'h0000, 1'b1, 4'd1, 16'h0001, 1'b0, 1'b0}
    };

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic clear_all();
        logic [15:0] t;
        rd(2'd0, t);
        wr(2'd0, 16'h0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(2'd0, rv); check("R1 status reset", rv, 16'h00C0);
        rd(2'd1, rv); check("R1 counter reset", rv, 16'h0000);
        rd(2'd2, rv); check("R1 reg A reset", rv, 16'h0000);
        check("R12 irq reset", {12'h0, irq}, 16'h0000);
        // R2 direction bit
        cnt_up = 1'b0;
        rd(2'd0, rv); check("R2 down dir", rv, 16'h0080);
        wr(2'd0, 16'h00FF);
        rd(2'd0, rv); check("R2 write ignored", rv, 16'h0080);
        cnt_up = 1'b1;

        // R13 / R3 / R4 vector table, both registers in capture mode
        for (int i = 0; i < 6; i++) begin
            wr(2'd1, VEC[i][38:23]);
            cnt_up = VEC[i][22];
            cnt_en = 1'b1;
            tick(int'(VEC[i][21:18]));
            cnt_en = 1'b0;
            rd(2'd1, rv); check("R13 count", rv, VEC[i][17:2]);
            rd(2'd0, rv);
            check("R3 R4 wrap flags", {14'h0, rv[5:4]}, {14'h0, VEC[i][0], VEC[i][1]});
            wr(2'd0, 16'h0000);
        end
        cnt_up = 1'b1;

        // R6 / R5 / R12 on overflow
        wr(2'd1, 16'hFFFF);
        cnt_en = 1'b1; tick(); cnt_en = 1'b0;
        check("R12 irq overflow", {12'h0, irq}, 16'h0004);
        irq_en = 4'b1011; #1;
        check("R12 irq gated", {12'h0, irq}, 16'h0000);
        irq_en = 4'hF;
        wr(2'd0, 16'h0000);
        rd(2'd0, rv); check("R6 unarmed write 0", rv, 16'h00D0);
        wr(2'd0, 16'h0010);
        rd(2'd0, rv); check("R5 write 1 no effect", rv, 16'h00D0);
        wr(2'd0, 16'h0000);
        rd(2'd0, rv); check("R5 read then write 0", rv, 16'h00C0);

        // R7 compare
        cap_mode = 2'b00;
        wr(2'd2, 16'h0010); wr(2'd3, 16'hF000); wr(2'd1, 16'h000E);
        cnt_en = 1'b1; tick(5); cnt_en = 1'b0;
        rd(2'd0, rv); check("R7 compare A only", rv, 16'h00C1);
        wr(2'd0, 16'h0000);

        // R11 set wins over clear, arming lost
        wr(2'd1, 16'h0100); wr(2'd2, 16'h0100);
        cnt_en = 1'b1; tick(); cnt_en = 1'b0;
        wr(2'd1, 16'h0100);
        rd(2'd0, rv); check("R11 flag A set", rv, 16'h00C1);
        cnt_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0000;
        tick();
        cnt_en = 1'b0; bus_wr = 1'b0;
        wr(2'd0, 16'h0000);
        rd(2'd0, rv); check("R11 set wins, disarmed", rv, 16'h00C1);
        wr(2'd0, 16'h0000);
        rd(2'd0, rv); check("R11 cleared after re-read", rv, 16'h00C0);

        // R8 capture rising on B
        cap_mode = 2'b10; cap_fall = 2'b00;
        wr(2'd1, 16'h5A5A);
        cap_in[1] = 1'b1;
        tick(2);
        rd(2'd3, rv); check("R8 not yet captured", rv, 16'hF000);
        tick(2);
        rd(2'd3, rv); check("R8 captured value", rv, 16'h5A5A);
        rd(2'd0, rv); check("R8 flag B", rv, 16'h00C2);
        wr(2'd0, 16'h0000);

        // R9 falling edge select
        cap_fall = 2'b10;
        cap_in[1] = 1'b0; tick(4);
        rd(2'd0, rv); check("R9 falling capture flag", rv, 16'h00C2);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h1111);
        cap_in[1] = 1'b1; tick(4);
        rd(2'd3, rv); check("R9 rising ignored value", rv, 16'h5A5A);
        rd(2'd0, rv); check("R9 rising ignored flag", rv, 16'h00C0);
        cap_in[1] = 1'b0; tick(4);
        rd(2'd3, rv); check("R9 falling capture value", rv, 16'h1111);

        // R10 service pulse
        svc_keep = 2'b10; svc_req = 2'b10; tick(); svc_req = 2'b00;
        rd(2'd0, rv); check("R10 keep holds flag", rv, 16'h00C2);
        svc_keep = 2'b00; svc_req = 2'b10; tick(); svc_req = 2'b00;
        rd(2'd0, rv); check("R10 service clears", rv, 16'h00C0);

        clear_all();
        finish_run();
    end
endmodule